// File: doc/BRIEF.md
# Burst-of-Two Dual-Port SRAM Model

This block is a clock-accurate, synthesizable model of a synchronous static memory with one shared address bus, an input-only write-data port and an output-only read-data port. Every access moves a pair of words. The two beats of a burst travel on opposite clock edges: one on the rising edge and one on the falling edge. A read and a write can both be accepted in the same cycle. The read address is taken from the bus at the rising edge, and the write address is taken from the same bus at the falling edge of that cycle.

Writes carry an active-low enable for each 9-bit byte lane, sampled separately for each beat. A write is committed to the array one rising edge after it is accepted. Until then it is held in a pending stage, and a read of the same pair that catches it there receives the stored words with the pending lanes merged in. Read data leaves through a dual-edge output stage. Beat 0 appears 1.5 cycles after the read is accepted and beat 1 half a cycle later, and a valid flag marks both beats. The data width (a multiple of 9) and the number of word pairs are parameters.

A two-state read-stage machine, clocked on the rising edge, decides whether the array is accessed:
- `RS_IDLE`: no read was accepted at the last rising edge.
- `RS_LOAD`: a read was accepted and the array fetch happens at the next rising edge.

Its transitions are:
- *accept* (`RS_IDLE`→`RS_LOAD`): `rd_n` is low.
- *chain* (`RS_LOAD`→`RS_LOAD`): back-to-back reads.
- *drain* (`RS_LOAD`→`RS_IDLE`): `rd_n` is high.
- *rest* (`RS_IDLE`→`RS_IDLE`): no read.

Top module: `b2_burst_sram`

## Requirements
- R1: While reset is low and after it is released, until the first read burst, `rvalid` is 0 and `rdata` is all zeros.
- R2: A read accepted at rising edge T (`rd_n` low) places the even word of the addressed pair on `rdata`, with `rvalid` high, during the low phase that starts at the falling edge of cycle T+1. It places the odd word, with `rvalid` high, during the high phase that starts at rising edge T+2.
- R3: A write accepted at rising edge T (`wr_n` low) takes beat 0 data and lane enables at that rising edge. It takes the write address and the beat 1 data and lane enables at the falling edge of the same cycle. Beat 0 goes to the even word of the pair and beat 1 to the odd word, and other pairs keep their contents.
- R4: Lane enable bit k (active low) gates data bits 9k to 9k+8. A lane whose bit is high keeps its stored value. Each beat uses its own enables, so the two words of one burst can be masked differently.
- R5: A read and a write accepted at the same rising edge both complete. The read uses the address present at the rising edge and the write uses the address present at the falling edge.
- R6: A read returns the newest data. A write to the same pair accepted in the same cycle as the read, or in any earlier cycle, is visible in the returned beats lane by lane.
- R7: In any half cycle that carries no read beat, `rvalid` is 0 and `rdata` holds the last beat that was driven.
- R8: Reads accepted on consecutive rising edges produce an unbroken stream of beats with `rvalid` continuously high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Pair address: read address at rising edge, write address at falling edge |
| rd_n | input | 1 | Active-low read select, sampled at rising edge |
| wr_n | input | 1 | Active-low write select, sampled at rising edge |
| wdata | input | DATA_W | Write data: beat 0 at rising edge, beat 1 at falling edge |
| bw_n | input | DATA_W/9 | Active-low lane write enables, per beat like `wdata` |
| rdata | output | DATA_W | Read data, beat 0 in low phase, beat 1 in high phase |
| rvalid | output | 1 | High while `rdata` carries a read beat |

## Verification
A read accepted at rising edge T has two results:
- beat 0, due in the low phase after the falling edge of cycle T+1;
- beat 1, due in the high phase after rising edge T+2.

A write accepted at T lands in the array at rising edge T+1. It is visible to reads accepted at T or later, through the merge path for T and through the array for later reads.

The bench counts rising edges. Each expectation is filed under the cycle its read was accepted. A monitor samples 2 ns into every half cycle and compares against the entry filed one cycle earlier (beat 0) or two cycles earlier (beat 1). A half cycle with no entry must show `rvalid` low and the held value. Sampling mid-phase keeps every check clear of both edges.

// File: rtl/b2sram_pkg.sv
package b2sram_pkg;

    // Width of one byte lane gated by one write-enable bit.
    localparam int LANE_W = 9;

    // Read-stage machine: is an array fetch due at the next rising edge?
    typedef enum logic [0:0] {
        RS_IDLE = 1'b0,
        RS_LOAD = 1'b1
    } rd_stage_t;

endpackage

// File: rtl/b2_in_capture.sv
module b2_in_capture
    import b2sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 36,
    parameter int LANES  = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LANES-1:0]  bw_n,
    output logic              fetch_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_live,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wd_even,
    output logic [DATA_W-1:0] wd_odd,
    output logic [LANES-1:0]  wm_even,
    output logic [LANES-1:0]  wm_odd
);

    rd_stage_t rs_q;
    rd_stage_t rs_d;

    // Next-state logic of the read stage: accept / chain / drain / rest.
    always_comb begin
        rs_d = rs_q;
        unique case (rs_q)
            RS_IDLE: rs_d = rd_n ? RS_IDLE : RS_LOAD;
            RS_LOAD: rs_d = rd_n ? RS_IDLE : RS_LOAD;
            default: rs_d = RS_IDLE;
        endcase
    end

    // State register and read address, taken at the rising edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q    <= RS_IDLE;
            rd_addr <= '0;
        end else begin
            rs_q <= rs_d;
            if (!rd_n) begin
                rd_addr <= addr;
            end
        end
    end

    // Output decode of the read stage.
    always_comb begin
        fetch_en = 1'b0;
        unique case (rs_q)
            RS_IDLE: fetch_en = 1'b0;
            RS_LOAD: fetch_en = 1'b1;
            default: fetch_en = 1'b0;
        endcase
    end

    // Write beat 0: select, data and lane enables at the rising edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_live <= 1'b0;
            wd_even <= '0;
            wm_even <= '1;
        end else begin
            wr_live <= ~wr_n;
            if (!wr_n) begin
                wd_even <= wdata;
                wm_even <= bw_n;
            end
        end
    end

    // Write beat 1 and the write address at the falling edge of the same cycle.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_addr <= '0;
            wd_odd  <= '0;
            wm_odd  <= '1;
        end else if (wr_live) begin
            wr_addr <= addr;
            wd_odd  <= wdata;
            wm_odd  <= bw_n;
        end
    end

endmodule

// File: rtl/b2_store.sv
module b2_store
    import b2sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 36,
    parameter int LANES  = DATA_W / LANE_W,
    parameter int PAIRS  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_live,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wd_even,
    input  logic [DATA_W-1:0] wd_odd,
    input  logic [LANES-1:0]  wm_even,
    input  logic [LANES-1:0]  wm_odd,
    output logic [DATA_W-1:0] pair_even,
    output logic [DATA_W-1:0] pair_odd,
    output logic              pair_ok
);

    logic [DATA_W-1:0] bank_e [PAIRS];
    logic [DATA_W-1:0] bank_o [PAIRS];
    logic              hit;

    // Lane-wise overlay of new data on an old word; enable bits are active low.
    function automatic logic [DATA_W-1:0] lane_merge(
        input logic [DATA_W-1:0] old_w,
        input logic [DATA_W-1:0] new_w,
        input logic [LANES-1:0]  en_n
    );
        logic [DATA_W-1:0] r;
        r = old_w;
        for (int k = 0; k < LANES; k++) begin
            if (!en_n[k]) begin
                r[k*LANE_W +: LANE_W] = new_w[k*LANE_W +: LANE_W];
            end
        end
        return r;
    endfunction

    // The pending write is still uncommitted when the fetch happens.
    assign hit = wr_live && (wr_addr == rd_addr);

    // Commit the pending write and fetch the requested pair on the same edge;
    // the fetch sees pre-edge array contents plus the forwarded lanes.
    always_ff @(posedge clk) begin
        if (wr_live) begin
            bank_e[wr_addr] <= lane_merge(bank_e[wr_addr], wd_even, wm_even);
            bank_o[wr_addr] <= lane_merge(bank_o[wr_addr], wd_odd,  wm_odd);
        end
        if (fetch_en) begin
            pair_even <= hit ? lane_merge(bank_e[rd_addr], wd_even, wm_even) : bank_e[rd_addr];
            pair_odd  <= hit ? lane_merge(bank_o[rd_addr], wd_odd,  wm_odd)  : bank_o[rd_addr];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pair_ok <= 1'b0;
        end else begin
            pair_ok <= fetch_en;
        end
    end

endmodule

// File: rtl/b2_ddr_out.sv
module b2_ddr_out #(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pair_ok,
    input  logic [DATA_W-1:0] pair_even,
    input  logic [DATA_W-1:0] pair_odd,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    logic [DATA_W-1:0] fall_q;
    logic [DATA_W-1:0] rise_q;
    logic              vfall_q;
    logic              vrise_q;

    // Beat 0 launches at the falling edge; when idle, copy the held beat.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fall_q  <= '0;
            vfall_q <= 1'b0;
        end else if (pair_ok) begin
            fall_q  <= pair_even;
            vfall_q <= 1'b1;
        end else begin
            fall_q  <= rise_q;
            vfall_q <= 1'b0;
        end
    end

    // Beat 1 launches at the next rising edge, before the pair is replaced.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_q  <= '0;
            vrise_q <= 1'b0;
        end else if (vfall_q) begin
            rise_q  <= pair_odd;
            vrise_q <= 1'b1;
        end else begin
            rise_q  <= fall_q;
            vrise_q <= 1'b0;
        end
    end

    // High phase shows the rising-edge register, low phase the falling-edge one.
    assign rdata  = clk ? rise_q  : fall_q;
    assign rvalid = clk ? vrise_q : vfall_q;

    // R7: after an idle falling edge both halves carry the same held beat.
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !vfall_q |-> (fall_q == rise_q));

endmodule

// File: rtl/b2_burst_sram.sv
module b2_burst_sram
    import b2sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 36
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     rd_n,
    input  logic                     wr_n,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [DATA_W/LANE_W-1:0] bw_n,
    output logic [DATA_W-1:0]        rdata,
    output logic                     rvalid
);

    localparam int LANES = DATA_W / LANE_W;
    localparam int PAIRS = 1 << ADDR_W;

    logic              fetch_en;
    logic [ADDR_W-1:0] rd_addr;
    logic              wr_live;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wd_even;
    logic [DATA_W-1:0] wd_odd;
    logic [LANES-1:0]  wm_even;
    logic [LANES-1:0]  wm_odd;
    logic [DATA_W-1:0] pair_even;
    logic [DATA_W-1:0] pair_odd;
    logic              pair_ok;

    b2_in_capture #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .wdata    (wdata),
        .bw_n     (bw_n),
        .fetch_en (fetch_en),
        .rd_addr  (rd_addr),
        .wr_live  (wr_live),
        .wr_addr  (wr_addr),
        .wd_even  (wd_even),
        .wd_odd   (wd_odd),
        .wm_even  (wm_even),
        .wm_odd   (wm_odd)
    );

    b2_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LANES  (LANES),
        .PAIRS  (PAIRS)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch_en  (fetch_en),
        .rd_addr   (rd_addr),
        .wr_live   (wr_live),
        .wr_addr   (wr_addr),
        .wd_even   (wd_even),
        .wd_odd    (wd_odd),
        .wm_even   (wm_even),
        .wm_odd    (wm_odd),
        .pair_even (pair_even),
        .pair_odd  (pair_odd),
        .pair_ok   (pair_ok)
    );

    b2_ddr_out #(
        .DATA_W (DATA_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .pair_ok   (pair_ok),
        .pair_even (pair_even),
        .pair_odd  (pair_odd),
        .rdata     (rdata),
        .rvalid    (rvalid)
    );

    // R2: an accepted read has its first beat launched before rising edge T+2.
    p_rd_beat_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> ##2 u_out.vfall_q);

    // R7: a rising edge without a read leaves the matching falling slot empty.
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n |-> ##2 !u_out.vfall_q);

    // R8: two reads in a row keep both output halves valid without a gap.
    p_stream_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n ##1 !rd_n) |-> ##2 (u_out.vfall_q && u_out.vrise_q));

endmodule

// File: tb/test_b2_burst_sram.sv
module test_b2_burst_sram;

    localparam int AW    = 6;
    localparam int DW    = 36;
    localparam int NL    = 4;
    localparam int NP    = 1 << AW;
    localparam int DEPTH = 4096;

    logic          clk   = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_n  = 1'b1;
    logic          wr_n  = 1'b1;
    logic [AW-1:0] addr  = '0;
    logic [DW-1:0] wdata = '0;
    logic [NL-1:0] bw_n  = '1;
    logic [DW-1:0] rdata;
    logic          rvalid;

    b2_burst_sram #(.ADDR_W(AW), .DATA_W(DW)) i_b2_burst_sram (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (addr),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .wdata  (wdata),
        .bw_n   (bw_n),
        .rdata  (rdata),
        .rvalid (rvalid)
    );

    always #4 clk = ~clk;   // 125 MHz

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    bit            rd_flag [DEPTH];
    logic [DW-1:0] exp0    [DEPTH];
    logic [DW-1:0] exp1    [DEPTH];
    string         tagv    [DEPTH];
    logic [DW-1:0] model_e [NP];
    logic [DW-1:0] model_o [NP];

    int            tests  = 0;
    int            fails  = 0;
    bit            mon_on = 0;
    bit            done   = 0;
    logic [DW-1:0] last_q = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [DW-1:0] got, input logic [DW-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                            input logic [DW-1:0] new_w,
                                            input logic [NL-1:0] en_n);
        logic [DW-1:0] r;
        r = old_w;
        for (int k = 0; k < NL; k++)
            if (!en_n[k]) r[k*9 +: 9] = new_w[k*9 +: 9];
        return r;
    endfunction

    function automatic logic [DW-1:0] pat(input int p, input int b, input int s);
        logic [63:0] v;
        v = 64'(p) * 64'h9E37_79B9 + 64'(b) * 64'h5_5A5A_3C3C + 64'(s) * 64'h1_2345_6789;
        return v[DW-1:0] ^ v[63:64-DW];
    endfunction

    // One clock cycle of stimulus; expectations are filed under the accepting edge.
    task automatic step(input bit rd, input bit wr, input int ra, input int wa,
                        input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                        input logic [NL-1:0] m0, input logic [NL-1:0] m1,
                        input string tag);
        int n;
        @(negedge clk); #2;
        n     = cyc + 1;
        rd_n  = !rd;
        wr_n  = !wr;
        addr  = AW'(ra);
        wdata = d0;
        bw_n  = m0;
        if (wr) begin
            model_e[wa] = merge(model_e[wa], d0, m0);
            model_o[wa] = merge(model_o[wa], d1, m1);
        end
        if (rd && n < DEPTH) begin
            rd_flag[n] = 1'b1;
            exp0[n]    = model_e[ra];
            exp1[n]    = model_o[ra];
            tagv[n]    = tag;
        end
        @(posedge clk); #2;
        addr  = AW'(wa);
        wdata = d1;
        bw_n  = m1;
    endtask

    task automatic idle();
        step(0, 0, 0, 0, '0, '0, '1, '1, "R7");
    endtask

    // Low-phase monitor: beat 0 of the read accepted one rising edge earlier.
    initial forever begin
        int m;
        @(negedge clk); #2;
        if (mon_on) begin
            m = cyc;
            if (m >= 1 && m - 1 < DEPTH && rd_flag[m-1]) begin
                check(rvalid === 1'b1 && rdata === exp0[m-1], tagv[m-1],
                      $sformatf("beat0 of read at edge %0d valid=%b", m - 1, rvalid),
                      rdata, exp0[m-1]);
                last_q = exp0[m-1];
            end else begin
                check(rvalid === 1'b0 && rdata === last_q, "R7",
                      $sformatf("idle low phase at edge %0d valid=%b", m, rvalid),
                      rdata, last_q);
            end
        end
    end

    // High-phase monitor: beat 1 of the read accepted two rising edges earlier.
    initial forever begin
        int m;
        @(posedge clk); #2;
        if (mon_on) begin
            m = cyc;
            if (m >= 2 && m - 2 < DEPTH && rd_flag[m-2]) begin
                check(rvalid === 1'b1 && rdata === exp1[m-2], tagv[m-2],
                      $sformatf("beat1 of read at edge %0d valid=%b", m - 2, rvalid),
                      rdata, exp1[m-2]);
                last_q = exp1[m-2];
            end else begin
                check(rvalid === 1'b0 && rdata === last_q, "R7",
                      $sformatf("idle high phase at edge %0d valid=%b", m, rvalid),
                      rdata, last_q);
            end
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, got %0d expected 0 hung cycles", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int k;
        int p;
        for (int i = 0; i < NP; i++) begin
            model_e[i] = '0;
            model_o[i] = '0;
        end

        // R1: outputs quiet while reset is held.
        repeat (3) @(negedge clk);
        #2;
        check(rvalid === 1'b0 && rdata === '0, "R1", "reset low phase", rdata, '0);
        @(posedge clk); #2;
        check(rvalid === 1'b0 && rdata === '0, "R1", "reset high phase", rdata, '0);
        @(negedge clk); #2;
        rst_n  = 1'b1;
        mon_on = 1'b1;
        idle();
        idle();
        check(rvalid === 1'b0 && rdata === '0, "R1", "after release", rdata, '0);

        // R3: fill the lower half with full-lane writes.
        for (int i = 0; i < 32; i++)
            step(0, 1, 0, i, pat(i, 0, 1), pat(i, 1, 1), '0, '0, "R3");

        // R5: fill the upper half while reading back the lower half on the same edges.
        for (int i = 32; i < 64; i++)
            step(1, 1, i - 32, i, pat(i, 0, 1), pat(i, 1, 1), '0, '0, "R5");

        // R2: isolated reads separated by idle cycles.
        for (int i = 32; i < 40; i++) begin
            step(1, 0, i, 0, '0, '0, '1, '1, "R2");
            idle();
            idle();
        end

        // R8: a full back-to-back sweep of every pair.
        for (int i = 0; i < NP; i++)
            step(1, 0, i, 0, '0, '0, '1, '1, "R8");
        repeat (3) idle();

        // R6: same-edge write and read of one pair, then a read right after a write.
        step(1, 1, 5, 5, pat(5, 0, 7), pat(5, 1, 7), 4'b0101, 4'b1010, "R6");
        idle();
        step(0, 1, 0, 6, pat(6, 0, 8), pat(6, 1, 8), 4'b0011, 4'b1100, "R6");
        step(1, 0, 6, 0, '0, '0, '1, '1, "R6");
        idle();
        step(0, 1, 0, 7, pat(7, 0, 9), pat(7, 1, 9), 4'b1110, 4'b0111, "R6");
        step(1, 1, 7, 7, pat(7, 0, 10), pat(7, 1, 10), 4'b1101, 4'b1011, "R6");
        idle();

        // R4: every pair of per-beat lane-enable patterns, through forward,
        // next-edge and gapped read paths.
        for (int m0 = 0; m0 < 16; m0++) begin
            for (int m1 = 0; m1 < 16; m1++) begin
                k = m0 * 16 + m1;
                p = 10 + (k % 8);
                step(0, 1, 0, p, pat(p, 0, 100 + k), pat(p, 1, 100 + k), '0, '0, "R4");
                if (k % 3 == 0) begin
                    step(1, 1, p, p, pat(p, 0, 600 + k), pat(p, 1, 600 + k),
                         NL'(m0), NL'(m1), "R4");
                end else begin
                    step(0, 1, 0, p, pat(p, 0, 600 + k), pat(p, 1, 600 + k),
                         NL'(m0), NL'(m1), "R4");
                    if (k % 3 == 2) idle();
                    step(1, 0, p, 0, '0, '0, '1, '1, "R4");
                end
            end
        end

        // R3: other pairs kept their contents through all of the above.
        for (int i = 40; i < 48; i++)
            step(1, 0, i, 0, '0, '0, '1, '1, "R3");
        repeat (4) idle();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule